// File: doc/BRIEF.md
# Processor Status and Banked Stack Pointer Unit

This block keeps the status word of a small processor together with its control registers, and owns general register 15, the live stack pointer. A second, hidden stack pointer stores the pointer of whichever stack mode is not active. The stack-mode bit of the status word decides which of the two pointers appears as register 15. Changing that bit through a status-word write exchanges the live pointer with the hidden one. The two stack-pointer control registers therefore reach either the live register or the hidden copy, depending on the mode.

Control registers are read through a combinational port and written through a clocked port. Both ports take a 3-bit index. The rest of the register file reads and writes register 15 through a dedicated port. The condition, interrupt-enable and stack-mode bits are also driven out directly so that neighbouring logic can use them.

Top module: `psw_sp_unit`

## Requirements
- R1: After reset every status bit, register 15, the hidden pointer and the storage registers at indices 4 to 6 read as zero.
- R2: Index 0 reads the status word: backup stack mode at bit 15, backup interrupt enable at bit 14, backup condition at bit 8, stack mode at bit 7, interrupt enable at bit 6 and condition at bit 0. Every other bit reads zero.
- R3: A write to index 0 loads each of those six bits from the same bit position of the written value and changes nothing else in the status word.
- R4: Index 1 reads the condition bit zero-extended. A write to index 1 sets the condition from bit 0 of the value and leaves the other status bits unchanged.
- R5: A status-word write that changes stack mode from 1 to 0 saves the old register 15 as the user pointer and loads register 15 with the interrupt pointer.
- R6: A status-word write that changes stack mode from 0 to 1 saves the old register 15 as the interrupt pointer and loads register 15 with the user pointer.
- R7: Index 2 (interrupt pointer) reads and writes register 15 when stack mode is 0, and the hidden copy when stack mode is 1.
- R8: Index 3 (user pointer) reads and writes register 15 when stack mode is 1, and the hidden copy when stack mode is 0.
- R9: Indices 4, 5 and 6 are plain full-width storage. Index 6 holds the backup program counter. Index 7 reads zero, and writes to it change no register.
- R10: A status-word write that keeps the stack-mode bit unchanged leaves register 15 and both stack pointers as they were.
- R11: If register 15 is written through its port in the same cycle as a mode-changing status-word write, the port value is what gets saved to the hidden pointer, and register 15 still takes the other mode's pointer.
- R12: If a control-register write to index 2 or 3 targets live register 15 in the same cycle as a register-15 port write, the control-register value is stored.
- R13: Writes take effect at the rising clock edge. Both read ports are combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr_we_i | input | 1 | Control-register write enable |
| cr_waddr_i | input | 3 | Control-register write index |
| cr_wdata_i | input | XLEN | Control-register write value |
| cr_raddr_i | input | 3 | Control-register read index |
| cr_rdata_o | output | XLEN | Control-register read value |
| gr15_we_i | input | 1 | Register-15 write enable |
| gr15_wdata_i | input | XLEN | Register-15 write value |
| gr15_rdata_o | output | XLEN | Live register 15 |
| cond_o | output | 1 | Condition bit |
| ie_o | output | 1 | Interrupt enable |
| sm_o | output | 1 | Stack mode |

## Verification
Each write is applied at a falling edge, and its effect is due one register stage later, at the next rising edge. The bench samples one time unit after that edge, once the write enables have been released. Reads involve no register, so after each update the bench sweeps all eight read indices and register 15 with a small settle delay, while the state is held, and compares them with a reference model. The model keeps separate interrupt and user pointers and updates them in order for each operation. Directed sequences cover both swap directions, the simultaneous-write priorities and the unused index. A long pseudo-random run then mixes writes to all indices with register-15 port writes.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned CR_IDX_W = 3;
  localparam int unsigned PSW_W    = 16;

  localparam int unsigned BIT_BSM   = 15;
  localparam int unsigned BIT_BIE   = 14;
  localparam int unsigned BIT_BCOND = 8;
  localparam int unsigned BIT_SM    = 7;
  localparam int unsigned BIT_IE    = 6;
  localparam int unsigned BIT_COND  = 0;

  typedef enum logic [CR_IDX_W-1:0] {
    CR_PSW  = 3'd0,
    CR_CBIT = 3'd1,
    CR_ISP  = 3'd2,
    CR_USP  = 3'd3,
    CR_GP4  = 3'd4,
    CR_GP5  = 3'd5,
    CR_BPC  = 3'd6,
    CR_NONE = 3'd7
  } cr_idx_e;

  typedef struct packed {
    logic bsm;
    logic bie;
    logic bcond;
    logic sm;
    logic ie;
    logic cond;
  } psw_t;

  function automatic logic [PSW_W-1:0] psw_pack(psw_t p);
    logic [PSW_W-1:0] w;
    w            = '0;
    w[BIT_BSM]   = p.bsm;
    w[BIT_BIE]   = p.bie;
    w[BIT_BCOND] = p.bcond;
    w[BIT_SM]    = p.sm;
    w[BIT_IE]    = p.ie;
    w[BIT_COND]  = p.cond;
    return w;
  endfunction

  function automatic psw_t psw_unpack(logic [PSW_W-1:0] w);
    psw_t p;
    p.bsm   = w[BIT_BSM];
    p.bie   = w[BIT_BIE];
    p.bcond = w[BIT_BCOND];
    p.sm    = w[BIT_SM];
    p.ie    = w[BIT_IE];
    p.cond  = w[BIT_COND];
    return p;
  endfunction
endpackage

// File: rtl/psw_status_reg.sv
module psw_status_reg
  import psw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psw_we_i,
  input  logic             cbit_we_i,
  input  logic [PSW_W-1:0] wdata_i,
  output psw_t             psw_o
);
  psw_t psw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (psw_we_i) begin
      psw_q <= psw_unpack(wdata_i);
    end else if (cbit_we_i) begin
      psw_q.cond <= wdata_i[BIT_COND];
    end
  end

  assign psw_o = psw_q;

  AST_CBIT_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbit_we_i && !psw_we_i |=> psw_q.sm == $past(psw_q.sm) && psw_q.ie == $past(psw_q.ie)
      && psw_q.bsm == $past(psw_q.bsm)); // R4
endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            swap_i,
  input  logic            cr_live_we_i,
  input  logic            cr_shadow_we_i,
  input  logic [XLEN-1:0] cr_wdata_i,
  input  logic            gr_we_i,
  input  logic [XLEN-1:0] gr_wdata_i,
  output logic [XLEN-1:0] live_o,
  output logic [XLEN-1:0] shadow_o
);
  logic [XLEN-1:0] live_q, shadow_q;
  logic [XLEN-1:0] live_eff;

  // value register 15 would hold this cycle absent a swap
  assign live_eff = gr_we_i ? gr_wdata_i : live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else if (swap_i) begin
      live_q   <= shadow_q;
      shadow_q <= live_eff;
    end else begin
      if (cr_live_we_i)   live_q   <= cr_wdata_i;
      else if (gr_we_i)   live_q   <= gr_wdata_i;
      if (cr_shadow_we_i) shadow_q <= cr_wdata_i;
    end
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;

  AST_SWAP_LOADS_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> live_q == $past(shadow_q)); // R5
  AST_SWAP_SAVES_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i && gr_we_i |=> shadow_q == $past(gr_wdata_i)); // R11
  AST_CR_BEATS_GR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i && cr_live_we_i && gr_we_i |=> live_q == $past(cr_wdata_i)); // R12
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cr_live_we_i && cr_shadow_we_i)); // R7
endmodule

// File: rtl/psw_cr_store.sv
module psw_cr_store #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned BASE  = 4,
  parameter int unsigned NUM   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic             rhit_o
);
  logic [NUM-1:0]  rsel;
  logic [XLEN-1:0] slot_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    localparam logic [IDX_W-1:0] IDX = IDX_W'(BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      slot_q[g] <= '0;
      else if (we_i && waddr_i == IDX)  slot_q[g] <= wdata_i;
    end
    assign rsel[g] = (raddr_i == IDX);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rsel[i]) rdata_o = slot_q[i];
    end
  end

  assign rhit_o = |rsel;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsel)); // R9
endmodule

// File: rtl/psw_sp_unit.sv
module psw_sp_unit
  import psw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cr_we_i,
  input  logic [CR_IDX_W-1:0] cr_waddr_i,
  input  logic [XLEN-1:0]     cr_wdata_i,
  input  logic [CR_IDX_W-1:0] cr_raddr_i,
  output logic [XLEN-1:0]     cr_rdata_o,
  input  logic                gr15_we_i,
  input  logic [XLEN-1:0]     gr15_wdata_i,
  output logic [XLEN-1:0]     gr15_rdata_o,
  output logic                cond_o,
  output logic                ie_o,
  output logic                sm_o
);
  localparam int unsigned NUM_GP = 3;
  localparam logic [XLEN-1:0] PSW_MASK = XLEN'(psw_pack('1));

  psw_t            psw;
  logic            psw_we, cbit_we, swap;
  logic            isp_we, usp_we, cr_live_we, cr_shadow_we;
  logic [XLEN-1:0] live, shadow, store_rdata;
  logic            store_hit;

  assign psw_we  = cr_we_i && (cr_waddr_i == CR_PSW);
  assign cbit_we = cr_we_i && (cr_waddr_i == CR_CBIT);
  assign isp_we  = cr_we_i && (cr_waddr_i == CR_ISP);
  assign usp_we  = cr_we_i && (cr_waddr_i == CR_USP);
  assign swap    = psw_we && (cr_wdata_i[BIT_SM] != psw.sm);

  // interrupt pointer is live in mode 0, user pointer is live in mode 1
  assign cr_live_we   = (isp_we && !psw.sm) || (usp_we && psw.sm);
  assign cr_shadow_we = (isp_we && psw.sm)  || (usp_we && !psw.sm);

  psw_status_reg u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psw_we_i  (psw_we),
    .cbit_we_i (cbit_we),
    .wdata_i   (cr_wdata_i[PSW_W-1:0]),
    .psw_o     (psw)
  );

  psw_sp_bank #(.XLEN(XLEN)) u_bank (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .swap_i         (swap),
    .cr_live_we_i   (cr_live_we),
    .cr_shadow_we_i (cr_shadow_we),
    .cr_wdata_i     (cr_wdata_i),
    .gr_we_i        (gr15_we_i),
    .gr_wdata_i     (gr15_wdata_i),
    .live_o         (live),
    .shadow_o       (shadow)
  );

  psw_cr_store #(
    .XLEN  (XLEN),
    .IDX_W (CR_IDX_W),
    .BASE  (int'(CR_GP4)),
    .NUM   (NUM_GP)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cr_we_i),
    .waddr_i (cr_waddr_i),
    .wdata_i (cr_wdata_i),
    .raddr_i (cr_raddr_i),
    .rdata_o (store_rdata),
    .rhit_o  (store_hit)
  );

  always_comb begin
    cr_rdata_o = '0;
    unique case (cr_raddr_i)
      CR_PSW:  cr_rdata_o = XLEN'(psw_pack(psw));
      CR_CBIT: cr_rdata_o = XLEN'(psw.cond);
      CR_ISP:  cr_rdata_o = psw.sm ? shadow : live;
      CR_USP:  cr_rdata_o = psw.sm ? live : shadow;
      CR_GP4, CR_GP5, CR_BPC: cr_rdata_o = store_hit ? store_rdata : '0;
      default: cr_rdata_o = '0;
    endcase
  end

  assign gr15_rdata_o = live;
  assign cond_o       = psw.cond;
  assign ie_o         = psw.ie;
  assign sm_o         = psw.sm;

  AST_PSW_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_raddr_i == CR_PSW |-> (cr_rdata_o & ~PSW_MASK) == '0); // R2
  AST_MODE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we |=> sm_o == $past(cr_wdata_i[BIT_SM]) && ie_o == $past(cr_wdata_i[BIT_IE])); // R3
  AST_NO_SWAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we && !swap && !gr15_we_i |=> $stable(gr15_rdata_o)); // R10
  AST_IDX7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_raddr_i == CR_NONE |-> cr_rdata_o == '0); // R9
endmodule

// File: tb/psw_sp_unit_test.sv
`timescale 1ns/1ps
module psw_sp_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cr_we_i = 1'b0;
  logic [2:0]      cr_waddr_i = '0;
  logic [XLEN-1:0] cr_wdata_i = '0;
  logic [2:0]      cr_raddr_i = '0;
  logic [XLEN-1:0] cr_rdata_o;
  logic            gr15_we_i = 1'b0;
  logic [XLEN-1:0] gr15_wdata_i = '0;
  logic [XLEN-1:0] gr15_rdata_o;
  logic            cond_o, ie_o, sm_o;

  int tests = 0;
  int fails = 0;

  // reference model: separate interrupt and user pointers
  logic            m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond;
  logic [XLEN-1:0] m_r15, m_isp, m_usp;
  logic [XLEN-1:0] m_gp [3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psw_sp_unit #(.XLEN(XLEN)) uut (
    .clk_i, .rst_ni, .cr_we_i, .cr_waddr_i, .cr_wdata_i, .cr_raddr_i, .cr_rdata_o,
    .gr15_we_i, .gr15_wdata_i, .gr15_rdata_o, .cond_o, .ie_o, .sm_o
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_cr(input int idx);
    case (idx)
      0: return (XLEN'(m_bsm) << 15) | (XLEN'(m_bie) << 14) | (XLEN'(m_bcond) << 8)
              | (XLEN'(m_sm) << 7) | (XLEN'(m_ie) << 6) | XLEN'(m_cond);
      1: return XLEN'(m_cond);
      2: return m_sm ? m_isp : m_r15;
      3: return m_sm ? m_r15 : m_usp;
      4, 5, 6: return m_gp[idx-4];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R2";
      1: return "R4";
      2: return "R7";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_all(input string pre);
    for (int i = 0; i < 8; i++) begin
      cr_raddr_i = 3'(i);
      #0.5;
      chk({pre, " ", tag_of(i), " idx"}, cr_rdata_o, exp_cr(i));
    end
    chk({pre, " R13 r15"}, gr15_rdata_o, m_r15);
    chk({pre, " R3 flags"}, XLEN'({cond_o, ie_o, sm_o}), XLEN'({m_cond, m_ie, m_sm}));
  endtask

  task automatic model_step(input logic cwe, input int wa, input logic [XLEN-1:0] wd,
                            input logic gwe, input logic [XLEN-1:0] gwd);
    logic [XLEN-1:0] r15_eff;
    logic old_sm;
    r15_eff = gwe ? gwd : m_r15;
    old_sm  = m_sm;
    if (gwe) m_r15 = gwd;
    if (cwe) begin
      case (wa)
        0: begin
          m_bsm = wd[15]; m_bie = wd[14]; m_bcond = wd[8];
          m_sm = wd[7]; m_ie = wd[6]; m_cond = wd[0];
          if (old_sm && !m_sm) begin
            m_usp = r15_eff; m_r15 = m_isp;
          end else if (!old_sm && m_sm) begin
            m_isp = r15_eff; m_r15 = m_usp;
          end
        end
        1: m_cond = wd[0];
        2: if (!m_sm) m_r15 = wd; else m_isp = wd;
        3: if (m_sm) m_r15 = wd; else m_usp = wd;
        4, 5, 6: m_gp[wa-4] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic do_op(input logic cwe, input int wa, input logic [XLEN-1:0] wd,
                       input logic gwe, input logic [XLEN-1:0] gwd);
    @(negedge clk_i);
    cr_we_i = cwe; cr_waddr_i = 3'(wa); cr_wdata_i = wd;
    gr15_we_i = gwe; gr15_wdata_i = gwd;
    @(posedge clk_i);
    #1;
    cr_we_i = 1'b0; gr15_we_i = 1'b0;
    model_step(cwe, wa, wd, gwe, gwd);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    {m_bsm, m_bie, m_bcond, m_sm, m_ie, m_cond} = '0;
    m_r15 = '0; m_isp = '0; m_usp = '0;
    for (int i = 0; i < 3; i++) m_gp[i] = '0;
    repeat (3) @(posedge clk_i);
    #1;
    check_all("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // mode 0: index 2 is live, index 3 is hidden
    do_op(1'b0, 0, '0, 1'b1, 32'h1111_0000);
    check_all("gr15 write");
    do_op(1'b1, 3, 32'h0000_AAAA, 1'b0, '0);
    check_all("usp shadow");
    chk("R8 r15 untouched", gr15_rdata_o, 32'h1111_0000);

    // 0 -> 1 swap
    do_op(1'b1, 0, 32'h0000_0080, 1'b0, '0);
    check_all("swap01");
    chk("R6 r15 from usp", gr15_rdata_o, 32'h0000_AAAA);
    cr_raddr_i = 3'd2; #0.5;
    chk("R6 isp saved", cr_rdata_o, 32'h1111_0000);

    // unchanged mode, all bits set
    do_op(1'b1, 0, 32'hFFFF_FFFF, 1'b0, '0);
    check_all("noswap");
    chk("R10 r15 kept", gr15_rdata_o, 32'h0000_AAAA);
    cr_raddr_i = 3'd0; #0.5;
    chk("R2 all flags", cr_rdata_o, 32'h0000_C1C1);

    // condition-only write
    do_op(1'b1, 1, 32'hFFFF_FFFE, 1'b0, '0);
    check_all("cbit");
    chk("R4 others kept", XLEN'({ie_o, sm_o, cond_o}), XLEN'(3'b110));

    // 1 -> 0 swap with simultaneous port write
    do_op(1'b1, 0, 32'h0000_0000, 1'b1, 32'h0000_5555);
    check_all("swap10");
    chk("R5 r15 from isp", gr15_rdata_o, 32'h1111_0000);
    cr_raddr_i = 3'd3; #0.5;
    chk("R11 port value saved", cr_rdata_o, 32'h0000_5555);

    // control write beats port write on live alias
    do_op(1'b1, 2, 32'h0000_0077, 1'b1, 32'h0000_0099);
    check_all("prio");
    chk("R12 cr wins", gr15_rdata_o, 32'h0000_0077);

    // storage and unused index
    do_op(1'b1, 4, 32'hDEAD_0004, 1'b0, '0);
    do_op(1'b1, 5, 32'hDEAD_0005, 1'b0, '0);
    do_op(1'b1, 6, 32'hDEAD_0006, 1'b0, '0);
    do_op(1'b1, 7, 32'hFFFF_FFFF, 1'b0, '0);
    check_all("store");
    cr_raddr_i = 3'd7; #0.5;
    chk("R9 idx7 zero", cr_rdata_o, '0);

    // R13 pseudo-random sweep
    for (int n = 0; n < 3000; n++) begin
      logic [XLEN-1:0] wd, gd;
      logic cwe, gwe;
      int wa;
      wd  = $urandom;
      gd  = $urandom;
      cwe = ($urandom % 4) != 0;
      gwe = ($urandom % 3) == 0;
      wa  = $urandom % 8;
      do_op(cwe, wa, wd, gwe, gd);
      check_all("R13 rand");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule